// File: doc/BRIEF.md
# Microprogram Address Sequencer with Return Stack

This block chooses the next microprogram address. It runs once per accepted instruction. Each cycle it reads a 12-bit microinstruction fetched from the current address, together with one external test condition, and updates an 11-bit microprogram counter. A small last-in-first-out stack holds subroutine return addresses and values pushed on purpose. The program store sits outside the block. It is addressed combinationally by `upc_o`, and its word comes back on `instr_i`.

The instruction word has these fields:

| Bits | Meaning |
|------|---------|
| [11:9] | Operation |
| [8] | Unconditional flag |
| [7] | Condition select |
| [6:0] | Branch target |

An operation takes effect when the unconditional flag is 1, or when the select bit is 1 and `test_i` is 1. Any other operation behaves as a plain continue. The operation codes are:

| Code | Operation |
|------|-----------|
| 000 | Load zero |
| 001 | Subroutine call |
| 010 | Jump |
| 011 | Push |
| 100 | Pop |
| 101 | Return |
| 110 | Jump via pipeline field, which acts like jump |
| 111 | Reserved for words that do not belong to the sequencer |

Instructions arrive as a stream qualified by `instr_v_i`. The sequencer has no ready output because it never applies back-pressure: it accepts every word offered with `instr_v_i` high in the same cycle. A cycle with `instr_v_i` low is a bubble, and all state holds through it.

Top module: `useq_core`

## Requirements
- R1: A synchronous reset sets `upc_o` to 0, empties the stack and clears both flags.
- R2: An operation is taken when bit 8 is 1, or when bit 7 is 1 and `test_i` is 1. An operation that is not taken advances `upc_o` by 1 and leaves the stack unchanged.
- R3: A taken load zero (code 000) sets `upc_o` to 0.
- R4: A taken jump (code 010) or pipeline jump (code 110) loads `upc_o` with bits [6:0] zero-extended to 11 bits.
- R5: A taken subroutine call (code 001) pushes `upc_o`+1 and loads the zero-extended branch target.
- R6: A taken return (code 101) pops the stack and loads `upc_o` with the popped entry.
- R7: A taken push (code 011) stores `upc_o`+1 on the stack. A taken pop (code 100) discards the top entry. Both then advance `upc_o` by 1.
- R8: The stack holds 8 entries. After 8 pushes, 8 pops return the entries in reverse order.
- R9: Code 111 always advances `upc_o` by 1 and leaves the stack unchanged, whatever bits 8 and 7 and `test_i` hold.
- R10: Advancing from address 2047 gives address 0.
- R11: A push onto a full stack overwrites the top entry, leaves the depth at 8 and pulses `ovf_o` high for the next cycle.
- R12: A pop from an empty stack yields 0, so a return goes to address 0. It leaves the stack empty and pulses `unf_o` high for the next cycle.
- R13: While `instr_v_i` is 0, `upc_o` and the stack hold their values and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_v_i | input | 1 | Instruction word valid |
| instr_i | input | 12 | Microinstruction read from address `upc_o` |
| test_i | input | 1 | External test condition |
| upc_o | output | 11 | Current microprogram address |
| ovf_o | output | 1 | Stack overflow pulse |
| unf_o | output | 1 | Stack underflow pulse |

## Verification
A wrong stack pointer or a corrupted entry stays hidden until a return consumes it. At that point `upc_o` lands on a wrong address, or `unf_o` and `ovf_o` pulse at the wrong depth, one cycle after the offending push, pop or return. A wrong counter or decode shows up one cycle after the instruction, as the wrong value on `upc_o`. The bench drives every combination of the 4-bit code, the select bit and `test_i` from a known stack state. It then runs a long pseudo-random instruction stream against an arithmetic model, so buried stack errors get a chance to reach `upc_o`.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    OP_LDZ  = 3'd0,
    OP_JSR  = 3'd1,
    OP_JMP  = 3'd2,
    OP_PUSH = 3'd3,
    OP_POP  = 3'd4,
    OP_RTN  = 3'd5,
    OP_JPP  = 3'd6,
    OP_PASS = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    NS_HOLD,
    NS_INC,
    NS_BR,
    NS_TOP,
    NS_ZERO
  } nsel_e;
endpackage

// File: rtl/useq_inc.sv
module useq_inc #(
  parameter int W = 11
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] carry;
  assign carry[0] = 1'b1;
  for (genvar i = 0; i < W; i++) begin : g_ripple
    assign sum_o[i]   = a_i[i] ^ carry[i];
    assign carry[i+1] = a_i[i] & carry[i];
  end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
#(
  parameter int BR_W = 7
) (
  input  logic            valid_i,
  input  logic [BR_W+4:0] instr_i,
  input  logic            test_i,
  output logic            push_o,
  output logic            pop_o,
  output nsel_e           nsel_o
);
  localparam int OP_LSB = BR_W + 2;

  op_e  op;
  logic taken;

  assign op    = op_e'(instr_i[OP_LSB +: 3]);
  assign taken = instr_i[BR_W+1] | (instr_i[BR_W] & test_i);

  always_comb begin
    push_o = 1'b0;
    pop_o  = 1'b0;
    nsel_o = NS_INC;
    if (!valid_i) begin
      nsel_o = NS_HOLD;
    end else if (taken) begin
      unique case (op)
        OP_LDZ:         nsel_o = NS_ZERO;
        OP_JSR:  begin  push_o = 1'b1; nsel_o = NS_BR;  end
        OP_JMP, OP_JPP: nsel_o = NS_BR;
        OP_PUSH:        push_o = 1'b1;
        OP_POP:         pop_o  = 1'b1;
        OP_RTN:  begin  pop_o  = 1'b1; nsel_o = NS_TOP; end
        default:        nsel_o = NS_INC;
      endcase
    end
  end
endmodule

// File: rtl/useq_lifo.sv
module useq_lifo #(
  parameter int W     = 11,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         ovf_o,
  output logic         unf_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          full, empty;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign top_o = empty ? '0 : mem[IW'(cnt_q - CW'(1))];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= push_i & full;
      unf_o <= pop_i & empty;
      if (push_i) begin
        if (full) begin
          mem[IW'(DEPTH - 1)] <= din_i;
        end else begin
          mem[IW'(cnt_q)] <= din_i;
          cnt_q <= cnt_q + CW'(1);
        end
      end else if (pop_i && !empty) begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

  assert_ovf_full_R11: assert property (@(posedge clk) disable iff (rst)
    (push_i && full) |=> (ovf_o && full && top_o == $past(din_i)));

  assert_unf_empty_R12: assert property (@(posedge clk) disable iff (rst)
    (pop_i && empty) |=> (unf_o && empty));

  assert_no_spurious_ovf_R11: assert property (@(posedge clk) disable iff (rst)
    !(push_i && full) |=> !ovf_o);
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int PC_W  = 11,
  parameter int BR_W  = 7,
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 instr_v_i,
  input  logic [BR_W+4:0]      instr_i,
  input  logic                 test_i,
  output logic [PC_W-1:0]      upc_o,
  output logic                 ovf_o,
  output logic                 unf_o
);
  localparam int OP_LSB = BR_W + 2;

  logic [PC_W-1:0] upc_q, upc_inc, upc_nxt, stk_top, br_ext;
  logic            do_push, do_pop;
  nsel_e           nsel;

  assign br_ext = PC_W'(instr_i[BR_W-1:0]);

  useq_inc #(.W(PC_W)) inc_i (
    .a_i   (upc_q),
    .sum_o (upc_inc)
  );

  useq_decode #(.BR_W(BR_W)) dec_i (
    .valid_i (instr_v_i),
    .instr_i (instr_i),
    .test_i  (test_i),
    .push_o  (do_push),
    .pop_o   (do_pop),
    .nsel_o  (nsel)
  );

  useq_lifo #(.W(PC_W), .DEPTH(DEPTH)) stk_i (
    .clk    (clk),
    .rst    (rst),
    .push_i (do_push),
    .pop_i  (do_pop),
    .din_i  (upc_inc),
    .top_o  (stk_top),
    .ovf_o  (ovf_o),
    .unf_o  (unf_o)
  );

  always_comb begin
    unique case (nsel)
      NS_HOLD: upc_nxt = upc_q;
      NS_BR:   upc_nxt = br_ext;
      NS_TOP:  upc_nxt = stk_top;
      NS_ZERO: upc_nxt = '0;
      default: upc_nxt = upc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc_q <= '0;
    else     upc_q <= upc_nxt;
  end

  assign upc_o = upc_q;

  logic taken_chk;
  assign taken_chk = instr_i[BR_W+1] | (instr_i[BR_W] & test_i);

  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (!instr_v_i && !rst) |=> ($stable(upc_q) && !ovf_o && !unf_o));

  assert_not_taken_R2: assert property (@(posedge clk) disable iff (rst)
    (instr_v_i && !taken_chk) |=> (upc_q == $past(upc_q) + PC_W'(1)));

  assert_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (instr_v_i && instr_i[OP_LSB +: 3] == 3'b111) |=> (upc_q == $past(upc_q) + PC_W'(1)));

  assert_ldz_R3: assert property (@(posedge clk) disable iff (rst)
    (instr_v_i && taken_chk && instr_i[OP_LSB +: 3] == 3'b000) |=> (upc_q == '0));

  assert_call_R5: assert property (@(posedge clk) disable iff (rst)
    (instr_v_i && taken_chk && instr_i[OP_LSB +: 3] == 3'b001) |=> (upc_q == $past(br_ext)));

  assert_return_R6: assert property (@(posedge clk) disable iff (rst)
    (instr_v_i && taken_chk && instr_i[OP_LSB +: 3] == 3'b101) |=> (upc_q == $past(stk_top)));

  assert_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (instr_v_i && upc_q == '1 && instr_i[OP_LSB +: 3] == 3'b111) |=> (upc_q == '0));
endmodule

// File: tb/useq_core_tb_top.sv
module useq_core_tb_top;
  localparam int PC_W  = 11;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             instr_v_i = 1'b0;
  logic [11:0]      instr_i = '0;
  logic             test_i = 1'b0;
  logic [PC_W-1:0]  upc_o;
  logic             ovf_o, unf_o;

  int checks = 0;
  int fails  = 0;

  logic [PC_W-1:0] mpc;
  logic [PC_W-1:0] mstk [DEPTH];
  int              mcnt;
  logic            movf, munf;

  always #5 clk = ~clk;

  useq_core dut_i (
    .clk       (clk),
    .rst       (rst),
    .instr_v_i (instr_v_i),
    .instr_i   (instr_i),
    .test_i    (test_i),
    .upc_o     (upc_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic m_push(input logic [PC_W-1:0] v);
    if (mcnt == DEPTH) begin
      mstk[DEPTH-1] = v;
      movf = 1'b1;
    end else begin
      mstk[mcnt] = v;
      mcnt++;
    end
  endtask

  task automatic m_pop(output logic [PC_W-1:0] v);
    if (mcnt == 0) begin
      v = '0;
      munf = 1'b1;
    end else begin
      mcnt--;
      v = mstk[mcnt];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; instr_v_i = 1'b0;
    @(posedge clk);
    #1;
    mpc = '0; mcnt = 0; movf = 1'b0; munf = 1'b0;
    chk("R1 pc", int'(upc_o), 0);
    chk("R1 ovf", int'(ovf_o), 0);
    chk("R1 unf", int'(unf_o), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input bit v, input logic [11:0] ins, input bit t);
    logic [PC_W-1:0] inc, br, popped;
    logic [2:0] op;
    bit taken;
    string tag;
    @(negedge clk);
    instr_v_i = v; instr_i = ins; test_i = t;
    @(posedge clk);
    op    = ins[11:9];
    taken = ins[8] | (ins[7] & t);
    inc   = mpc + PC_W'(1);
    br    = PC_W'(ins[6:0]);
    movf  = 1'b0; munf = 1'b0;
    if (!v) tag = "R13";
    else if (op == 3'd7) tag = "R9";
    else if (!taken) tag = "R2";
    else case (op)
      3'd0: tag = "R3";
      3'd1: tag = "R5";
      3'd3, 3'd4: tag = "R7";
      3'd5: tag = "R6";
      default: tag = "R4";
    endcase
    if (v) begin
      if (!taken || op == 3'd7) mpc = inc;
      else case (op)
        3'd0: mpc = '0;
        3'd1: begin m_push(inc); mpc = br; end
        3'd3: begin m_push(inc); mpc = inc; end
        3'd4: begin m_pop(popped); mpc = inc; end
        3'd5: begin m_pop(popped); mpc = popped; end
        default: mpc = br;
      endcase
    end
    #1;
    chk(tag, int'(upc_o), int'(mpc));
    chk("R11 ovf", int'(ovf_o), int'(movf));
    chk("R12 unf", int'(unf_o), int'(munf));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] lcg;
    do_reset();

    // Sweep: every 4-bit code with every select/test combination
    for (int code = 0; code < 16; code++) begin
      for (int s = 0; s < 2; s++) begin
        for (int t = 0; t < 2; t++) begin
          do_reset();
          step(1'b1, 12'h700, 1'b0);
          step(1'b1, 12'h700, 1'b0);
          step(1'b1, 12'he00, 1'b0);
          step(1'b1, {code[3:0], s[0], 7'h55}, t[0]);
          step(1'b1, 12'hb00, 1'b0);
          step(1'b1, 12'hb00, 1'b0);
        end
      end
    end

    // R8: eight pushes then eight returns in reverse order
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1'b1, 12'h700, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 12'hb00, 1'b0);
      chk("R8 lifo order", int'(upc_o), DEPTH - i);
    end
    // R12: one more return on empty goes to 0
    step(1'b1, 12'hb00, 1'b0);
    chk("R12 empty return", int'(upc_o), 0);
    chk("R12 flag", int'(unf_o), 1);
    step(1'b1, 12'h900, 1'b0);
    chk("R12 empty pop flag", int'(unf_o), 1);

    // R11: ninth push overwrites the top
    do_reset();
    for (int i = 0; i < DEPTH + 1; i++) step(1'b1, 12'h700, 1'b0);
    chk("R11 flag", int'(ovf_o), 1);
    step(1'b1, 12'hb00, 1'b0);
    chk("R11 overwritten top", int'(upc_o), DEPTH + 1);
    step(1'b1, 12'hb00, 1'b0);
    chk("R11 below top", int'(upc_o), DEPTH - 1);

    // R13: bubbles hold everything
    step(1'b1, 12'h700, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 12'h000, 1'b1);
    step(1'b1, 12'hb00, 1'b0);

    // R10: full counter wrap
    do_reset();
    for (int i = 0; i < 2047; i++) step(1'b1, 12'hf80, 1'b1);
    chk("R10 top address", int'(upc_o), 2047);
    step(1'b1, 12'he00, 1'b0);
    chk("R10 wrap", int'(upc_o), 0);

    // Pseudo-random stream against the model
    do_reset();
    lcg = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      step(lcg[30:28] != 3'd0, lcg[27:16], lcg[5]);
    end

    summary();
  end
endmodule